// File: doc/BRIEF.md
# Bus-Snooping Indirect Address Mapper

This block sits on the cartridge side of an 8-bit 6502-style bus. It is for interpreters that step through a large data image one byte at a time. It holds a 16-bit pointer split into a low byte register and a high byte register. Together they address an extension ROM and an extension RAM of up to 128K each. The seventeenth address bit comes from CPU address bit 0 of the access that reaches the extension memory.

The pointer bytes are loaded by snooping the data bus. Any access inside the mapper window loads one or both bytes with whatever byte is on the bus, whether the access is a read or a write. Address bit 4 selects the low byte and address bit 5 selects the high byte. Because reads load as well, a single read-modify-write increment at a snooped address both updates software's copy of the pointer and moves the hardware pointer.

Loads take effect when the M2 phase ends, so an extension access in the same cycle still uses the old pointer. The upper half of the CPU space selects a fixed, unbanked main ROM of 16K or 32K. A 16K main ROM repeats across that half. The design runs on a fast system clock and samples M2 as an ordinary input.

Top module: `ptr_window_mapper`

## Requirements
- R1: After synchronous reset both pointer bytes are zero, so ext_addr[15:0] reads 0, and every select output is low while M2 is low.
- R2: A pointer byte may change only after an access with romsel_n high (CPU A15 low) and cpu_addr[12] high. Accesses at $0000-$0FFF-type addresses (A12 low), or with romsel_n low, leave both bytes unchanged.
- R3: In a window access, cpu_addr[4] high loads the low byte from the bus and cpu_addr[5] high loads the high byte. With both bits high, both bytes receive the same byte. With neither bit high, neither byte changes.
- R4: Loading ignores rw. A read (rw=1) loads the byte present on bus_data exactly as a write (rw=0) does.
- R5: A load becomes visible on ext_addr only after M2 falls. Throughout the M2-high phase of the loading access, ext_addr carries the pointer value from before that access.
- R6: ext_rom_cs is high exactly when M2 is high, romsel_n is high, cpu_addr[12], cpu_addr[11] and cpu_addr[2] are high. ext_ram_cs uses the same condition with cpu_addr[2] low. The two selects are never high together.
- R7: ext_addr[16] equals cpu_addr[0], ext_addr[15:8] is the high byte and ext_addr[7:0] is the low byte.
- R8: ext_ram_we is high exactly when ext_ram_cs is high and rw is 0. ext_rom_cs does not depend on rw.
- R9: main_rom_cs is high exactly when romsel_n is low. main_rom_addr is cpu_addr[14:0] for a 32K main ROM, and {1'b0, cpu_addr[13:0]} for a 16K main ROM.
- R10: While M2 is low, ext_rom_cs, ext_ram_cs and ext_ram_we are low, and no load is collected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU M2 phase; high while an access is valid |
| romsel_n | input | 1 | Low when CPU A15 is high during M2 |
| cpu_addr | input | 15 | CPU address bits 14..0 |
| rw | input | 1 | CPU read (1) / write (0) |
| bus_data | input | 8 | Byte present on the data bus, from any driver |
| ext_rom_cs | output | 1 | Extension ROM select |
| ext_ram_cs | output | 1 | Extension RAM select |
| ext_ram_we | output | 1 | Extension RAM write strobe |
| ext_addr | output | 17 | Extension memory address |
| main_rom_cs | output | 1 | Fixed main ROM select |
| main_rom_addr | output | 15 | Main ROM address, mirrored for 16K |

## Verification
A wrong pointer byte shows up on ext_addr[15:0] in the first M2-low window after the access that loaded it. The model compares the address there and again during the next access. The same window exposes a stuck pending flag or a swapped lane at once. A decode fault shows on the select outputs during the M2-high phase of the very access that triggers it. A load committed too early shows on ext_addr during that same access.

// File: rtl/ptrmap_pkg.sv
package ptrmap_pkg;

    localparam int DATA_W   = 8;
    localparam int LANES    = 2;
    localparam int LANE_LO  = 0;
    localparam int LANE_HI  = 1;
    localparam int CPU_AW   = 15;

    // Address bits the decoder looks at
    localparam int BIT_WIN  = 12;
    localparam int BIT_EXT  = 11;
    localparam int BIT_ROM  = 2;
    localparam int BIT_LO   = 4;
    localparam int BIT_HI   = 5;

    typedef struct packed {
        logic             win;
        logic [LANES-1:0] load;
        logic             rom_sel;
        logic             ram_sel;
    } dec_t;

    function automatic dec_t decode(input logic romsel_n,
                                    input logic m2,
                                    input logic [CPU_AW-1:0] a);
        dec_t d;
        logic live;
        d.win     = romsel_n & a[BIT_WIN];
        live      = d.win & m2;
        d.load    = '0;
        d.load[LANE_LO] = live & a[BIT_LO];
        d.load[LANE_HI] = live & a[BIT_HI];
        d.rom_sel = live & a[BIT_EXT] &  a[BIT_ROM];
        d.ram_sel = live & a[BIT_EXT] & ~a[BIT_ROM];
        return d;
    endfunction

endpackage

// File: rtl/ptrmap_decode.sv
module ptrmap_decode
    import ptrmap_pkg::*;
(
    input  logic              m2,
    input  logic              romsel_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    output dec_t              dec
);

    always_comb begin
        dec = decode(romsel_n, m2, cpu_addr);
    end

endmodule

// File: rtl/ptrmap_ptr.sv
module ptrmap_ptr #(
    parameter int LANES_P = 2,
    parameter int DW      = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  m2,
    input  logic [LANES_P-1:0]    load,
    input  logic [DW-1:0]         d,
    output logic [LANES_P*DW-1:0] q
);

    logic          m2_q;
    logic          m2_fall;
    logic [DW-1:0] stage;

    always_ff @(posedge clk) begin
        if (rst) begin
            m2_q  <= 1'b0;
            stage <= '0;
        end else begin
            m2_q <= m2;
            if (|load) stage <= d;
        end
    end

    assign m2_fall = m2_q & ~m2;

    for (genvar g = 0; g < LANES_P; g++) begin : g_lane
        logic          pend;
        logic [DW-1:0] val;

        always_ff @(posedge clk) begin
            if (rst) begin
                pend <= 1'b0;
                val  <= '0;
            end else if (m2_fall) begin
                if (pend) val <= stage;
                pend <= 1'b0;
            end else if (load[g]) begin
                pend <= 1'b1;
            end
        end

        assign q[g*DW +: DW] = val;
    end

endmodule

// File: rtl/ptr_window_mapper.sv
module ptr_window_mapper
    import ptrmap_pkg::*;
#(
    parameter int MAIN_ROM_KB = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              m2,
    input  logic              romsel_n,
    input  logic [14:0]       cpu_addr,
    input  logic              rw,
    input  logic [7:0]        bus_data,
    output logic              ext_rom_cs,
    output logic              ext_ram_cs,
    output logic              ext_ram_we,
    output logic [16:0]       ext_addr,
    output logic              main_rom_cs,
    output logic [14:0]       main_rom_addr
);

    localparam int MAIN_AW = $clog2(MAIN_ROM_KB * 1024);

    dec_t                    dec;
    logic [LANES*DATA_W-1:0] ptr;

    ptrmap_decode u_dec (
        .m2       (m2),
        .romsel_n (romsel_n),
        .cpu_addr (cpu_addr),
        .dec      (dec)
    );

    ptrmap_ptr #(.LANES_P(LANES), .DW(DATA_W)) u_ptr (
        .clk  (clk),
        .rst  (rst),
        .m2   (m2),
        .load (dec.load),
        .d    (bus_data),
        .q    (ptr)
    );

    assign ext_rom_cs = dec.rom_sel;
    assign ext_ram_cs = dec.ram_sel;
    assign ext_ram_we = dec.ram_sel & ~rw;
    assign ext_addr   = {cpu_addr[0],
                         ptr[LANE_HI*DATA_W +: DATA_W],
                         ptr[LANE_LO*DATA_W +: DATA_W]};
    assign main_rom_cs = ~romsel_n;

    if (MAIN_AW >= 15) begin : g_main_full
        assign main_rom_addr = cpu_addr;
    end else begin : g_main_mirror
        assign main_rom_addr = {{(15-MAIN_AW){1'b0}}, cpu_addr[MAIN_AW-1:0]};
    end

endmodule

// File: rtl/ptr_window_mapper_chk.sv
module ptr_window_mapper_chk (
    input logic        clk,
    input logic        rst,
    input logic        m2,
    input logic        romsel_n,
    input logic [14:0] cpu_addr,
    input logic        rw,
    input logic        ext_rom_cs,
    input logic        ext_ram_cs,
    input logic        ext_ram_we,
    input logic [16:0] ext_addr,
    input logic        main_rom_cs
);

    assert_excl_sel_R6: assert property (@(posedge clk) disable iff (rst)
        !(ext_rom_cs && ext_ram_cs));

    assert_ext_in_window_R6: assert property (@(posedge clk) disable iff (rst)
        (ext_rom_cs || ext_ram_cs) |-> (romsel_n && cpu_addr[12] && cpu_addr[11]));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !m2 |-> !(ext_rom_cs || ext_ram_cs || ext_ram_we));

    assert_hold_in_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (m2 && $past(m2)) |-> $stable(ext_addr[15:0]));

    assert_change_after_fall_R5: assert property (@(posedge clk) disable iff (rst)
        !($past(m2) && !m2) |=> $stable(ext_addr[15:0]));

    assert_we_gated_R8: assert property (@(posedge clk) disable iff (rst)
        ext_ram_we |-> (ext_ram_cs && !rw));

    assert_main_excl_R9: assert property (@(posedge clk) disable iff (rst)
        main_rom_cs |-> !(ext_rom_cs || ext_ram_cs));

endmodule

bind ptr_window_mapper ptr_window_mapper_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .m2          (m2),
    .romsel_n    (romsel_n),
    .cpu_addr    (cpu_addr),
    .rw          (rw),
    .ext_rom_cs  (ext_rom_cs),
    .ext_ram_cs  (ext_ram_cs),
    .ext_ram_we  (ext_ram_we),
    .ext_addr    (ext_addr),
    .main_rom_cs (main_rom_cs)
);

// File: tb/ptr_window_mapper_test.sv
module ptr_window_mapper_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        m2 = 1'b0;
    logic        romsel_n = 1'b1;
    logic [14:0] cpu_addr = '0;
    logic        rw = 1'b1;
    logic [7:0]  bus_data = '0;

    logic        ext_rom_cs, ext_ram_cs, ext_ram_we, main_rom_cs;
    logic [16:0] ext_addr;
    logic [14:0] main_rom_addr;
    logic        h_rom_cs, h_ram_cs, h_ram_we, h_main_cs;
    logic [16:0] h_ext_addr;
    logic [14:0] h_main_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [7:0] lo_m = '0;
    logic [7:0] hi_m = '0;

    always #5 clk = ~clk;

    ptr_window_mapper uut (
        .clk(clk), .rst(rst), .m2(m2), .romsel_n(romsel_n),
        .cpu_addr(cpu_addr), .rw(rw), .bus_data(bus_data),
        .ext_rom_cs(ext_rom_cs), .ext_ram_cs(ext_ram_cs),
        .ext_ram_we(ext_ram_we), .ext_addr(ext_addr),
        .main_rom_cs(main_rom_cs), .main_rom_addr(main_rom_addr)
    );

    ptr_window_mapper #(.MAIN_ROM_KB(16)) uut_half (
        .clk(clk), .rst(rst), .m2(m2), .romsel_n(romsel_n),
        .cpu_addr(cpu_addr), .rw(rw), .bus_data(bus_data),
        .ext_rom_cs(h_rom_cs), .ext_ram_cs(h_ram_cs),
        .ext_ram_we(h_ram_we), .ext_addr(h_ext_addr),
        .main_rom_cs(h_main_cs), .main_rom_addr(h_main_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic in_win(input logic [15:0] a);
        return !a[15] && a[12];
    endfunction

    function automatic logic exp_rom(input logic [15:0] a);
        return in_win(a) && a[11] && a[2];
    endfunction

    function automatic logic exp_ram(input logic [15:0] a);
        return in_win(a) && a[11] && !a[2];
    endfunction

    task automatic access(input logic [15:0] a, input logic r, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a[14:0];
        rw       = r;
        bus_data = d;
        m2       = 1'b1;
        romsel_n = ~a[15];
        @(negedge clk);
        // phase high: selects and the pre-access pointer
        check("R6 rom_cs", {31'd0, ext_rom_cs}, {31'd0, exp_rom(a)});
        check("R6 ram_cs", {31'd0, ext_ram_cs}, {31'd0, exp_ram(a)});
        check("R8 ram_we", {31'd0, ext_ram_we}, {31'd0, exp_ram(a) && !r});
        check("R9 main_cs", {31'd0, main_rom_cs}, {31'd0, a[15]});
        check("R9 main_addr32", {17'd0, main_rom_addr}, {17'd0, a[14:0]});
        check("R9 main_addr16", {17'd0, h_main_addr}, {18'd0, a[13:0]});
        check("R5 R7 addr during access", {15'd0, ext_addr}, {15'd0, a[0], hi_m, lo_m});
        @(negedge clk);
        m2       = 1'b0;
        romsel_n = 1'b1;
        @(negedge clk);
        if (in_win(a)) begin
            if (a[4]) lo_m = d;
            if (a[5]) hi_m = d;
        end
        check("R2 R3 R4 addr after access", {15'd0, ext_addr}, {15'd0, a[0], hi_m, lo_m});
        check("R10 idle selects", {29'd0, ext_rom_cs, ext_ram_cs, ext_ram_we},
              32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] a;
        void'($urandom(32'h1234_5678));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 reset pointer", {16'd0, ext_addr[15:0]}, 32'd0);
        check("R1 reset selects", {28'd0, ext_rom_cs, ext_ram_cs, ext_ram_we, main_rom_cs}, 32'd0);

        // R3 low byte via write, R4 high byte via read
        access(16'h1010, 1'b0, 8'h5A);
        access(16'h1020, 1'b1, 8'hC3);
        // R3 both bytes same value
        access(16'h3030, 1'b1, 8'h77);
        // R3 neither bit
        access(16'h5000, 1'b0, 8'hEE);
        // R2 outside window: A12 low, and A15 high
        access(16'h0030, 1'b0, 8'h11);
        access(16'h9030, 1'b1, 8'h22);
        access(16'h6F30, 1'b0, 8'h33);
        // R6 R7 extension ROM read with A0 set, R8 rom ignores rw
        access(16'h5805, 1'b1, 8'h99);
        access(16'h7805, 1'b0, 8'h98);
        // R8 extension RAM write that also loads low byte; R5 old pointer used
        access(16'h5811, 1'b0, 8'hA1);
        access(16'h5830, 1'b1, 8'h4B);
        // R9 mirrored main ROM top address
        access(16'hFFFF, 1'b1, 8'h00);
        access(16'hC000, 1'b1, 8'h00);

        for (int i = 0; i < 400; i++) begin
            a = 16'($urandom);
            if (($urandom % 3) != 0) a[15] = 1'b0;
            if (($urandom % 2) != 0) a[12] = 1'b1;
            access(a, 1'($urandom), 8'($urandom));
        end

        // R1 reset again clears a loaded pointer
        access(16'h1030, 1'b0, 8'hFF);
        @(negedge clk);
        rst = 1'b1;
        lo_m = '0;
        hi_m = '0;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset after load", {16'd0, ext_addr[15:0]}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule